// File: doc/BRIEF.md
# Frame-Synchronous Channel Shadow Buffer

This block sits between a CPU register port and a time-slot serial engine that carries per-port voice and signalling channels. Each port has two byte-wide bearer channels (B1 and B2) and one narrow signalling channel (D) per frame. The CPU writes outgoing channel data into holding registers and reads incoming data from receive registers. Every data path goes through a shadow stage that moves only on the frame strobe, a single-cycle pulse at the 2 kHz frame rate (one frame is four 125 µs slots).

On each strobe the block raises a frame interrupt. At the same strobe it loads the holding data into the transmit shadow that drives the slot engine, captures the slot engine's receive data into a receive shadow, and promotes the previous receive shadow to the CPU-visible register. Software therefore writes frame n+1 and reads frame n-1 in the same service window, and a byte crosses the block in two frames (1 ms). A loopback input can feed the transmit shadow into the receive capture in place of the line.

Top module: `fcb_frame_buffer`

## Requirements
- R1: After reset every holding, shadow and receive register reads zero, `slot_tx_data` is zero and `irq_frame` is low.
- R2: A write to address p (0 ≤ p < NUM_PORTS) loads the holding register of port p. The port word holds B1 in bits [7:0], B2 in bits [15:8] and D in bits [17:16]. Reading address p returns the holding value, and `slot_tx_data` does not change until the next strobe.
- R3: On a strobe, each enabled channel's transmit shadow takes its holding value. The port's slice `slot_tx_data[p*18 +: 18]` shows it from the next cycle on.
- R4: On a strobe, each enabled channel captures its `slot_rx_data` field into the receive shadow and moves the previous shadow to the receive register at address NUM_PORTS+p. Line data present at strobe k is therefore readable after strobe k+1.
- R5: With `loopback` high, the receive capture takes the transmit shadow instead of the line. Data written before strobe k reads back from the receive register after strobe k+2 and not before.
- R6: Between strobes, the transmit shadow, receive shadow and receive registers hold their values whatever the CPU writes or the line presents.
- R7: `chan_en[p*3+c]` enables channel c of port p (c=0 for B1, 1 for B2, 2 for D). For a disabled channel, the transmit, receive-shadow and receive fields keep their values across strobes.
- R8: Every strobe sets `irq_frame`. Writing 1 to bit 0 at address 2*NUM_PORTS clears it, and that bit reads back the flag. Writing 0 has no effect, and a strobe in the same cycle as a clear leaves the flag set.
- R9: Writes to receive addresses change nothing. Reads of addresses above 2*NUM_PORTS return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle frame boundary pulse |
| loopback | input | 1 | Feed transmit shadow into receive capture |
| chan_en | input | NUM_PORTS*3 | Per-port, per-channel enables |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_frame | output | 1 | Frame interrupt flag |
| slot_tx_data | output | NUM_PORTS*18 | Transmit shadow data to the slot engine |
| slot_rx_data | input | NUM_PORTS*18 | Received channel data from the slot engine |

## Verification
Transmit tests use a mixed-bit word on one port, to tell the holding stage from the shadow stage. Receive tests use two different line words on successive frames, which shows whether data lands after one strobe or after two. Loopback tests check the receive register at each of three strobes, so a design that is early or late by one frame fails. An all-ones word with one channel disabled shows that only that field is frozen, and clear tests include a clear that coincides with a strobe, which fixes the priority.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
   localparam int CH_PER_PORT = 3;
   localparam int CH_D        = 2;

   function automatic int chan_lsb(input int ch, input int bw);
      return ch * bw;
   endfunction

   function automatic int chan_width(input int ch, input int bw, input int dw);
      return (ch == CH_D) ? dw : bw;
   endfunction
endpackage

// File: rtl/fcb_stage.sv
module fcb_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_stb,
   input  logic         en,
   input  logic         loop_sel,
   input  logic [W-1:0] tx_hold,
   input  logic [W-1:0] rx_line,
   output logic [W-1:0] tx_sh,
   output logic [W-1:0] rx_cpu
);
   logic [W-1:0] tx_q, rx_sh_q, rx_cpu_q;
   logic [W-1:0] rx_src;

   initial begin
      if (W < 1) $error("fcb_stage: W must be positive");
   end

   assign rx_src = loop_sel ? tx_q : rx_line;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q     <= '0;
         rx_sh_q  <= '0;
         rx_cpu_q <= '0;
      end else if (frame_stb && en) begin
         tx_q     <= tx_hold;
         rx_sh_q  <= rx_src;
         rx_cpu_q <= rx_sh_q;
      end
   end

   assign tx_sh  = tx_q;
   assign rx_cpu = rx_cpu_q;

   p_tx_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && en) |=> (tx_sh == $past(tx_hold)));
   p_rx_promote_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && en) |=> (rx_cpu == $past(rx_sh_q)));
   p_loop_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && en && loop_sel) |=> (rx_sh_q == $past(tx_sh)));
   p_quiet_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> ($stable(tx_sh) && $stable(rx_sh_q) && $stable(rx_cpu)));
   p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && !en) |=> ($stable(tx_sh) && $stable(rx_sh_q) && $stable(rx_cpu)));
endmodule

// File: rtl/fcb_regif.sv
module fcb_regif #(
   parameter int NUM_PORTS = 4,
   parameter int PW        = 18,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_stb,
   input  logic                    reg_wr,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [DATA_W-1:0]       reg_wdata,
   input  logic [NUM_PORTS*PW-1:0] rx_cpu_flat,
   output logic [NUM_PORTS*PW-1:0] hold_flat,
   output logic [DATA_W-1:0]       reg_rdata,
   output logic                    irq
);
   localparam int RX_BASE   = NUM_PORTS;
   localparam int STAT_ADDR = 2 * NUM_PORTS;

   logic [PW-1:0] hold_q [NUM_PORTS];
   logic          irq_q;
   logic          clr_req;

   assign clr_req = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR)) && reg_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PORTS; p++) hold_q[p] <= '0;
      end else if (reg_wr) begin
         for (int p = 0; p < NUM_PORTS; p++)
            if (reg_addr == ADDR_W'(p)) hold_q[p] <= reg_wdata[PW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          irq_q <= 1'b0;
      else if (frame_stb)  irq_q <= 1'b1;
      else if (clr_req)    irq_q <= 1'b0;
   end

   always_comb begin
      reg_rdata = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (reg_addr == ADDR_W'(p))
            reg_rdata[PW-1:0] = hold_q[p];
         if (reg_addr == ADDR_W'(RX_BASE + p))
            reg_rdata[PW-1:0] = rx_cpu_flat[p*PW +: PW];
      end
      if (reg_addr == ADDR_W'(STAT_ADDR)) reg_rdata[0] = irq_q;
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_flat
      assign hold_flat[p*PW +: PW] = hold_q[p];
   end

   assign irq = irq_q;

   p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> irq);
   p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !frame_stb) |=> !irq);
   p_rx_space_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr >= ADDR_W'(RX_BASE))) |=> (hold_flat == $past(hold_flat)));
endmodule

// File: rtl/fcb_frame_buffer.sv
module fcb_frame_buffer #(
   parameter int NUM_PORTS    = 4,
   parameter int B_W          = 8,
   parameter int D_W          = 2,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 4,
   parameter bit HAS_LOOPBACK = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   frame_stb,
   input  logic                                   loopback,
   input  logic [NUM_PORTS*fcb_pkg::CH_PER_PORT-1:0] chan_en,
   input  logic                                   reg_wr,
   input  logic [ADDR_W-1:0]                      reg_addr,
   input  logic [DATA_W-1:0]                      reg_wdata,
   output logic [DATA_W-1:0]                      reg_rdata,
   output logic                                   irq_frame,
   output logic [NUM_PORTS*(2*B_W+D_W)-1:0]       slot_tx_data,
   input  logic [NUM_PORTS*(2*B_W+D_W)-1:0]       slot_rx_data
);
   import fcb_pkg::*;

   localparam int PW  = 2 * B_W + D_W;
   localparam int TOT = NUM_PORTS * PW;

   if (PW > DATA_W) begin : g_bad_width
      $error("fcb_frame_buffer: port word wider than DATA_W");
   end
   if (2 * NUM_PORTS + 1 > (1 << ADDR_W)) begin : g_bad_addr
      $error("fcb_frame_buffer: ADDR_W too small for register map");
   end

   logic [TOT-1:0] hold_flat, rx_cpu_flat;
   logic           loop_sel;

   if (HAS_LOOPBACK) begin : g_loop
      assign loop_sel = loopback;
   end else begin : g_noloop
      assign loop_sel = 1'b0;
   end

   fcb_regif #(
      .NUM_PORTS(NUM_PORTS), .PW(PW), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regif (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_stb  (frame_stb),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .rx_cpu_flat(rx_cpu_flat),
      .hold_flat  (hold_flat),
      .reg_rdata  (reg_rdata),
      .irq        (irq_frame)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      for (genvar c = 0; c < CH_PER_PORT; c++) begin : g_chan
         localparam int LSB = p * PW + chan_lsb(c, B_W);
         localparam int CW  = chan_width(c, B_W, D_W);
         fcb_stage #(.W(CW)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .frame_stb(frame_stb),
            .en       (chan_en[p*CH_PER_PORT + c]),
            .loop_sel (loop_sel),
            .tx_hold  (hold_flat[LSB +: CW]),
            .rx_line  (slot_rx_data[LSB +: CW]),
            .tx_sh    (slot_tx_data[LSB +: CW]),
            .rx_cpu   (rx_cpu_flat[LSB +: CW])
         );
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!irq_frame && (slot_tx_data == '0)));
endmodule

// File: tb/fcb_frame_buffer_tb.sv
module fcb_frame_buffer_tb;
   localparam int NP = 4;
   localparam int PW = 18;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_stb = 1'b0;
   logic              loopback = 1'b0;
   logic [NP*3-1:0]   chan_en = '1;
   logic              reg_wr = 1'b0;
   logic [3:0]        reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              irq_frame;
   logic [NP*PW-1:0]  slot_tx_data;
   logic [NP*PW-1:0]  slot_rx_data = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fcb_frame_buffer u_dut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .loopback(loopback),
      .chan_en(chan_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_frame(irq_frame),
      .slot_tx_data(slot_tx_data), .slot_rx_data(slot_rx_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 d = reg_rdata;
   endtask

   task automatic strobe();
      @(negedge clk);
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
   endtask

   function automatic logic [31:0] txp(input int p);
      return 32'(slot_tx_data[p*PW +: PW]);
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 irq", 32'(irq_frame), 0);
      chk("R1 tx line", 32'(slot_tx_data == '0), 1);
      rd(0, v);  chk("R1 hold p0", v, 0);
      rd(NP, v); chk("R1 rx p0", v, 0);
      rd(2*NP, v); chk("R1 status", v, 0);
   endtask

   task automatic t_write_tx();
      logic [31:0] v;
      wr(0, 32'h2A55A);
      rd(0, v); chk("R2 readback", v, 32'h2A55A);
      chk("R2 line unchanged before strobe", txp(0), 0);
      strobe();
      chk("R3 line after strobe", txp(0), 32'h2A55A);
      chk("R8 irq set by strobe", 32'(irq_frame), 1);
   endtask

   task automatic t_rx_pipe();
      logic [31:0] v;
      slot_rx_data[1*PW +: PW] = 18'h1ABCD;
      strobe();
      rd(NP+1, v); chk("R4 not yet after one strobe", v, 0);
      slot_rx_data[1*PW +: PW] = 18'h23456;
      strobe();
      rd(NP+1, v); chk("R4 first word after two strobes", v, 32'h1ABCD);
      strobe();
      rd(NP+1, v); chk("R4 second word", v, 32'h23456);
   endtask

   task automatic t_quiet();
      logic [31:0] tx0, rx0, v;
      tx0 = txp(1);
      rd(NP+1, rx0);
      wr(1, 32'h11111);
      slot_rx_data[1*PW +: PW] = 18'h3C3C3;
      repeat (5) @(negedge clk);
      chk("R6 tx line held", txp(1), tx0);
      rd(NP+1, v); chk("R6 rx reg held", v, rx0);
   endtask

   task automatic t_loop();
      logic [31:0] v;
      loopback = 1'b1;
      wr(2, 32'h35A5A);
      strobe();
      rd(NP+2, v); chk("R5 not after k", v, 0);
      strobe();
      rd(NP+2, v); chk("R5 not after k+1", v, 0);
      strobe();
      rd(NP+2, v); chk("R5 visible after k+2", v, 32'h35A5A);
      loopback = 1'b0;
   endtask

   task automatic t_disable();
      logic [31:0] v;
      chan_en[3*3+1] = 1'b0;
      wr(3, 32'h3FFFF);
      slot_rx_data[3*PW +: PW] = 18'h3FFFF;
      strobe();
      chk("R7 B2 frozen on tx line", txp(3), 32'h300FF);
      strobe();
      rd(NP+3, v); chk("R7 B2 frozen in rx reg", v, 32'h300FF);
      chan_en = '1;
   endtask

   task automatic t_irq();
      logic [31:0] v;
      strobe();
      wr(2*NP, 32'h0);
      chk("R8 write zero ignored", 32'(irq_frame), 1);
      rd(2*NP, v); chk("R8 status reads flag", v, 1);
      wr(2*NP, 32'h1);
      chk("R8 cleared", 32'(irq_frame), 0);
      @(negedge clk);
      frame_stb = 1'b1; reg_wr = 1'b1; reg_addr = 4'(2*NP); reg_wdata = 32'h1;
      @(negedge clk);
      frame_stb = 1'b0; reg_wr = 1'b0;
      chk("R8 strobe beats clear", 32'(irq_frame), 1);
   endtask

   task automatic t_map();
      logic [31:0] v;
      wr(NP, 32'h12345);
      rd(NP, v); chk("R9 rx write ignored", v, 0);
      rd(0, v);  chk("R9 hold untouched", v, 32'h2A55A);
      rd(2*NP+1, v); chk("R9 unmapped reads zero", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_tx();
      t_rx_pipe();
      t_quiet();
      t_loop();
      t_disable();
      t_irq();
      t_map();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule